// File: doc/BRIEF.md
# Three-Wire Host Register Interface

This block is a register-access slave for a host bus made of three wires: a host clock, an active-low frame strobe and one bidirectional data line. The wires are brought into the block's system clock through synchronizers, and edges of the host clock are detected there. Each frame starts with a direction bit and a broadcast flag. An 8-bit address follows, then a 16-bit data word. On a write, the host sends the data word and the block commits it one clock later. On a read, the block leaves one turnaround clock and then shifts the addressed register out, most significant bit first. It drives its own output-enable so that a pad can share the line.

The register file holds four channel banks and a small central group. The channel banks sit at 00h, 20h, 40h and 60h, each with `BANK_REGS` registers. The central group sits at 80h–83h, and 83h is a read-only identifier. A broadcast write puts the same word into the same offset of all four channel banks. All register contents are brought out in parallel for the logic that uses them.

Top module: `host_reg_if`

## Requirements
- R1: After reset every writable register reads 0000h, the identifier at 83h reads 8010h, and the output enable is low.
- R2: A write frame is bit 1 = 0, bit 2 = broadcast flag, bits 3–10 = address MSB first, bits 11–26 = data MSB first. A later read of that address returns the data.
- R3: A write with broadcast flag 0 to a channel address changes only the bank chosen by address bits 6:5, at the offset given by address bits 4:0.
- R4: A write with broadcast flag 1 to a channel address (bit 7 = 0) stores the word at offset address[4:0] in all four banks, whatever address bits 6:5 are.
- R5: Addresses 80h, 81h and 82h are readable and writable central registers. The broadcast flag has no effect on them.
- R6: Address 83h always reads 8010h. Writes to it have no effect.
- R7: A read frame has bit 1 = 1. The output enable stays low up to the falling edge of host clock 11. From that edge on, the block drives data bit 15, then one lower bit on each following falling edge, so that the host samples bits 15..0 on rising edges 12..27.
- R8: The block releases the data line (output enable low) at the falling edge of host clock 27 of a read frame.
- R9: A write takes effect only at rising edge 27. If the strobe rises before that edge, no register changes.
- R10: When the strobe rises in the middle of a read frame, the output enable goes low within a few system clocks.
- R11: Channel offsets at or above BANK_REGS and central addresses 84h–FFh read 0000h. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the host wires |
| rstN | input | 1 | Active-low asynchronous reset |
| hostClk | input | 1 | Host bus clock; may stop low when the bus is idle |
| hostStrobeN | input | 1 | Active-low frame strobe |
| hostDataIn | input | 1 | Data line as seen from the pad input |
| hostDataOut | output | 1 | Serial read data towards the pad |
| hostDataOe | output | 1 | Output enable of the data pad |
| chanCfg | output | 4*BANK_REGS*16 | All channel registers, bank-major, 16 bits each |
| centralCfg | output | 48 | Central registers 80h–82h, 16 bits each |

## Verification
The hardest situation to reach from the ports is a strobe that rises between the end of the data bits and the commit clock. The frame then looks complete in its data but must leave the register file untouched. The bench gets there with a frame task that stops after a chosen host clock number: it delivers all 16 data bits, withholds rising edge 27, and then reads the register back. The same task stops a read in its data phase, to check that the pad is released, and it records the output enable just before rising edges 11 and 12 to pin down the turnaround.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 16;
  localparam int CHAN_BANKS  = 4;
  localparam int CENTRAL_RW  = 3;
  localparam int ID_INDEX    = 3;
  localparam int OFF_W       = ADDR_W - 3;
  localparam int HDR_BITS    = 1 + ADDR_W;
  localparam int DATA_FIRST  = HDR_BITS + 1;
  localparam int DATA_LAST   = HDR_BITS + DATA_W;
  localparam int COMMIT_AT   = DATA_LAST + 1;
  localparam int DRIVE_AT    = HDR_BITS + 2;
  localparam int DROP_AT     = DRIVE_AT + DATA_W;
  localparam int CNT_W       = $clog2(DROP_AT + 2);

  typedef struct packed {
    logic shiftHdr;
    logic shiftData;
    logic commit;
    logic loadOut;
    logic shiftOut;
    logic dropOut;
  } hreg_strobes_t;
endpackage

// File: rtl/hreg_ctrl.sv
module hreg_ctrl
  import hreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostClk,
  input  logic             hostStrobeN,
  input  logic             hostDataIn,
  output hreg_strobes_t    strb,
  output logic             inBit,
  output logic [CNT_W-1:0] bitCnt,
  output logic             isRead
);
  logic [SYNC_STAGES-1:0] clkS, stbS, datS;
  logic clkPrev, stbPrev, active;
  logic hClk, hStb, rise, fall, start, live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkS    <= '0;
      stbS    <= '1;
      datS    <= '0;
      clkPrev <= 1'b0;
      stbPrev <= 1'b1;
    end else begin
      clkS    <= {clkS[SYNC_STAGES-2:0], hostClk};
      stbS    <= {stbS[SYNC_STAGES-2:0], hostStrobeN};
      datS    <= {datS[SYNC_STAGES-2:0], hostDataIn};
      clkPrev <= clkS[SYNC_STAGES-1];
      stbPrev <= stbS[SYNC_STAGES-1];
    end
  end

  assign hClk  = clkS[SYNC_STAGES-1];
  assign hStb  = stbS[SYNC_STAGES-1];
  assign inBit = datS[SYNC_STAGES-1];
  assign rise  = hClk & ~clkPrev;
  assign fall  = ~hClk & clkPrev;
  assign start = ~hStb & stbPrev;
  assign live  = active & ~hStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else begin
      if (hStb) active <= 1'b0;
      else if (start) active <= 1'b1;

      if (hStb || start) bitCnt <= '0;
      else if (live && rise && bitCnt != '1) bitCnt <= bitCnt + 1'b1;

      if (start) isRead <= 1'b0;
      else if (live && rise && bitCnt == '0) isRead <= inBit;
    end
  end

  always_comb begin
    strb = '0;
    strb.shiftHdr  = live & rise & (bitCnt >= CNT_W'(1)) & (bitCnt <= CNT_W'(HDR_BITS));
    strb.shiftData = live & rise & ~isRead &
                     (bitCnt >= CNT_W'(DATA_FIRST)) & (bitCnt <= CNT_W'(DATA_LAST));
    strb.commit    = live & rise & ~isRead & (bitCnt == CNT_W'(COMMIT_AT));
    strb.loadOut   = live & fall & isRead & (bitCnt == CNT_W'(DRIVE_AT));
    strb.shiftOut  = live & fall & isRead &
                     (bitCnt > CNT_W'(DRIVE_AT)) & (bitCnt < CNT_W'(DROP_AT));
    strb.dropOut   = hStb | (live & fall & isRead & (bitCnt == CNT_W'(DROP_AT)));
  end
endmodule

// File: rtl/hreg_datapath.sv
module hreg_datapath
  import hreg_pkg::*;
#(
  parameter int              BANK_REGS = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 16'h8010
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  hreg_strobes_t                          strb,
  input  logic                                   inBit,
  output logic                                   hostDataOut,
  output logic                                   hostDataOe,
  output logic [CHAN_BANKS*BANK_REGS*DATA_W-1:0] chanCfg,
  output logic [CENTRAL_RW*DATA_W-1:0]           centralCfg
);
  logic [HDR_BITS-1:0] hdr;
  logic [DATA_W-1:0]   wData, outSr, rdData;
  logic [DATA_W-1:0]   chanReg [CHAN_BANKS][BANK_REGS];
  logic [DATA_W-1:0]   cenReg  [CENTRAL_RW];
  logic [ADDR_W-1:0]   addr;
  logic                bcast, isChan;
  logic [OFF_W-1:0]    offset;
  logic [1:0]          bankSel;
  logic [ADDR_W-2:0]   cenIdx;

  assign addr    = hdr[ADDR_W-1:0];
  assign bcast   = hdr[HDR_BITS-1];
  assign isChan  = ~addr[ADDR_W-1];
  assign offset  = addr[OFF_W-1:0];
  assign bankSel = addr[ADDR_W-2:OFF_W];
  assign cenIdx  = addr[ADDR_W-2:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdr   <= '0;
      wData <= '0;
    end else begin
      if (strb.shiftHdr)  hdr   <= {hdr[HDR_BITS-2:0], inBit};
      if (strb.shiftData) wData <= {wData[DATA_W-2:0], inBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < CHAN_BANKS; b++)
        for (int r = 0; r < BANK_REGS; r++)
          chanReg[b][r] <= '0;
      for (int c = 0; c < CENTRAL_RW; c++)
        cenReg[c] <= '0;
    end else if (strb.commit) begin
      for (int b = 0; b < CHAN_BANKS; b++)
        for (int r = 0; r < BANK_REGS; r++)
          if (isChan && offset == OFF_W'(r) && (bcast || bankSel == 2'(b)))
            chanReg[b][r] <= wData;
      for (int c = 0; c < CENTRAL_RW; c++)
        if (!isChan && cenIdx == (ADDR_W-1)'(c))
          cenReg[c] <= wData;
    end
  end

  always_comb begin
    rdData = '0;
    if (isChan) begin
      for (int r = 0; r < BANK_REGS; r++)
        if (offset == OFF_W'(r)) rdData = chanReg[bankSel][r];
    end else begin
      for (int c = 0; c < CENTRAL_RW; c++)
        if (cenIdx == (ADDR_W-1)'(c)) rdData = cenReg[c];
      if (cenIdx == (ADDR_W-1)'(ID_INDEX)) rdData = ID_VALUE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSr      <= '0;
      hostDataOe <= 1'b0;
    end else begin
      if (strb.dropOut) begin
        hostDataOe <= 1'b0;
        outSr      <= '0;
      end else if (strb.loadOut) begin
        hostDataOe <= 1'b1;
        outSr      <= rdData;
      end else if (strb.shiftOut) begin
        outSr      <= {outSr[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign hostDataOut = outSr[DATA_W-1];

  for (genvar gb = 0; gb < CHAN_BANKS; gb++) begin : g_bank
    for (genvar gr = 0; gr < BANK_REGS; gr++) begin : g_reg
      assign chanCfg[(gb*BANK_REGS+gr)*DATA_W +: DATA_W] = chanReg[gb][gr];
    end
  end
  for (genvar gc = 0; gc < CENTRAL_RW; gc++) begin : g_cen
    assign centralCfg[gc*DATA_W +: DATA_W] = cenReg[gc];
  end
endmodule

// File: rtl/host_reg_if.sv
module host_reg_if
  import hreg_pkg::*;
#(
  parameter int                BANK_REGS   = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_VALUE    = 16'h8010
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   hostClk,
  input  logic                                   hostStrobeN,
  input  logic                                   hostDataIn,
  output logic                                   hostDataOut,
  output logic                                   hostDataOe,
  output logic [CHAN_BANKS*BANK_REGS*DATA_W-1:0] chanCfg,
  output logic [CENTRAL_RW*DATA_W-1:0]           centralCfg
);
  hreg_strobes_t    strb;
  logic             inBit;
  logic [CNT_W-1:0] bitCnt;
  logic             isRead;

  hreg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostClk(hostClk), .hostStrobeN(hostStrobeN),
    .hostDataIn(hostDataIn), .strb(strb), .inBit(inBit), .bitCnt(bitCnt),
    .isRead(isRead)
  );

  hreg_datapath #(.BANK_REGS(BANK_REGS), .ID_VALUE(ID_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inBit(inBit),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .chanCfg(chanCfg), .centralCfg(centralCfg)
  );
endmodule

// File: rtl/host_reg_if_checker.sv
module host_reg_if_checker
  import hreg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             hostStrobeN,
  input logic             hostDataOe,
  input hreg_strobes_t    strb,
  input logic [CNT_W-1:0] bitCnt,
  input logic             isRead
);
  logic [2:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highRun <= '0;
    else if (!hostStrobeN) highRun <= '0;
    else if (highRun != '1) highRun <= highRun + 1'b1;
  end

  // R7: the pad is only ever driven inside a read frame
  p_oe_read_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> isRead);

  // R7: driving starts at the turnaround falling edge
  p_drive_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostDataOe) |-> (bitCnt == CNT_W'(DRIVE_AT)));

  // R10: a strobe held high releases the line
  p_release_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (highRun >= 3'd4) |-> !hostDataOe);

  // R9: a commit never happens while the pad is driven
  p_commit_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !hostDataOe);

  // R2: at most one frame action per system clock
  p_one_action_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftHdr, strb.shiftData, strb.commit, strb.loadOut, strb.shiftOut}));
endmodule

bind host_reg_if host_reg_if_checker u_chk (
  .clk(clk), .rstN(rstN), .hostStrobeN(hostStrobeN), .hostDataOe(hostDataOe),
  .strb(strb), .bitCnt(bitCnt), .isRead(isRead)
);

// File: tb/test_host_reg_if.sv
module test_host_reg_if;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int BANK_REGS  = 8;
  localparam int FULL       = 27;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostClk = 1'b0, hostStrobeN = 1'b1, hostDataIn = 1'b0;
  logic hostDataOut, hostDataOe;
  logic [4*BANK_REGS*16-1:0] chanCfg;
  logic [47:0] centralCfg;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_reg_if #(.BANK_REGS(BANK_REGS)) i_host_reg_if (
    .clk(clk), .rstN(rstN), .hostClk(hostClk), .hostStrobeN(hostStrobeN),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .chanCfg(chanCfg), .centralCfg(centralCfg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic d, output logic b, output logic o);
    hostDataIn = d;
    repeat (HALF) @(negedge clk);
    b = hostDataOut;
    o = hostDataOe;
    hostClk = 1'b1;
    repeat (HALF) @(negedge clk);
    hostClk = 1'b0;
  endtask

  task automatic frame(input logic rw, input logic bc, input logic [7:0] addr,
                       input logic [15:0] wdat, input int stopAfter,
                       output logic [15:0] rdat, output logic oe11, output logic oe12,
                       output logic oeEnd, output logic oeIdle);
    logic b, o;
    rdat = '0; oe11 = 1'b0; oe12 = 1'b0;
    @(negedge clk);
    hostStrobeN = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 1; k <= stopAfter; k++) begin
      logic d;
      if (k == 1) d = rw;
      else if (k == 2) d = bc;
      else if (k <= 10) d = addr[10-k];
      else if (k <= 26 && !rw) d = wdat[26-k];
      else d = 1'b0;
      pulse(d, b, o);
      if (k == 11) oe11 = o;
      if (k == 12) oe12 = o;
      if (k >= 12 && k <= 27) rdat[27-k] = b;
    end
    repeat (HALF) @(negedge clk);
    oeEnd = hostDataOe;
    hostStrobeN = 1'b1;
    repeat (8) @(negedge clk);
    oeIdle = hostDataOe;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic wr(input logic bc, input logic [7:0] addr, input logic [15:0] d);
    logic [15:0] r; logic a, b, c, e;
    frame(1'b0, bc, addr, d, FULL, r, a, b, c, e);
  endtask

  task automatic rd(input logic [7:0] addr, output logic [15:0] r);
    logic a, b, c, e;
    frame(1'b1, 1'b0, addr, 16'h0, FULL, r, a, b, c, e);
  endtask

  task automatic testReset();
    logic [15:0] r;
    check("R1 oe after reset", {15'd0, hostDataOe}, 16'h0);
    rd(8'h00, r); check("R1 reg 00h", r, 16'h0000);
    rd(8'h25, r); check("R1 reg 25h", r, 16'h0000);
    rd(8'h80, r); check("R1 reg 80h", r, 16'h0000);
    rd(8'h83, r); check("R1 id 83h", r, 16'h8010);
  endtask

  task automatic testSingle();
    logic [15:0] r;
    wr(1'b0, 8'h23, 16'hA5C3);
    rd(8'h23, r); check("R2 readback 23h", r, 16'hA5C3);
    rd(8'h03, r); check("R3 bank0 untouched", r, 16'h0000);
    rd(8'h43, r); check("R3 bank2 untouched", r, 16'h0000);
    rd(8'h63, r); check("R3 bank3 untouched", r, 16'h0000);
    rd(8'h22, r); check("R3 neighbour offset untouched", r, 16'h0000);
  endtask

  task automatic testBroadcast();
    logic [15:0] r;
    wr(1'b1, 8'h45, 16'h1234);
    for (int b = 0; b < 4; b++) begin
      rd(8'(b*32 + 5), r);
      check($sformatf("R4 bank%0d offset 5", b), r, 16'h1234);
    end
    check("R4 port bank2 offset5", chanCfg[(2*BANK_REGS+5)*16 +: 16], 16'h1234);
  endtask

  task automatic testCentral();
    logic [15:0] r;
    wr(1'b1, 8'h81, 16'hBEEF);
    wr(1'b0, 8'h80, 16'h0F0F);
    wr(1'b0, 8'h82, 16'h8001);
    rd(8'h81, r); check("R5 central 81h", r, 16'hBEEF);
    rd(8'h80, r); check("R5 central 80h", r, 16'h0F0F);
    rd(8'h82, r); check("R5 central 82h", r, 16'h8001);
    rd(8'h01, r); check("R5 bcast ignored bank0", r, 16'h0000);
    rd(8'h21, r); check("R5 bcast ignored bank1", r, 16'h0000);
  endtask

  task automatic testIdReadOnly();
    logic [15:0] r;
    wr(1'b0, 8'h83, 16'h0000);
    rd(8'h83, r); check("R6 id after write", r, 16'h8010);
  endtask

  task automatic testTurnaround();
    logic [15:0] r; logic o11, o12, oEnd, oIdle;
    wr(1'b0, 8'h67, 16'hC35A);
    frame(1'b1, 1'b0, 8'h67, 16'h0, FULL, r, o11, o12, oEnd, oIdle);
    check("R7 oe low before rise 11", {15'd0, o11}, 16'h0);
    check("R7 oe high before rise 12", {15'd0, o12}, 16'h1);
    check("R7 data MSB first", r, 16'hC35A);
    check("R8 released after fall 27", {15'd0, oEnd}, 16'h0);
  endtask

  task automatic testAbortWrite();
    logic [15:0] r; logic a, b, c, e;
    frame(1'b0, 1'b0, 8'h06, 16'hFFFF, 26, r, a, b, c, e);
    rd(8'h06, r); check("R9 aborted write no change", r, 16'h0000);
    frame(1'b0, 1'b1, 8'h07, 16'hFFFF, 15, r, a, b, c, e);
    rd(8'h27, r); check("R9 aborted bcast no change", r, 16'h0000);
  endtask

  task automatic testAbortRead();
    logic [15:0] r; logic a, b, oEnd, oIdle;
    frame(1'b1, 1'b0, 8'h83, 16'h0, 14, r, a, b, oEnd, oIdle);
    check("R10 driving mid read", {15'd0, oEnd}, 16'h1);
    check("R10 released on strobe", {15'd0, oIdle}, 16'h0);
  endtask

  task automatic testUnmapped();
    logic [15:0] r;
    wr(1'b0, 8'h1F, 16'h7777);
    rd(8'h1F, r); check("R11 offset 31 reads zero", r, 16'h0000);
    wr(1'b0, 8'h90, 16'h5555);
    rd(8'h90, r); check("R11 90h reads zero", r, 16'h0000);
    rd(8'h80, r); check("R11 80h unchanged", r, 16'h0F0F);
    rd(8'h10, r); check("R11 10h unmapped", r, 16'h0000);
    check("R11 central port unchanged", centralCfg[15:0], 16'h0F0F);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testSingle();
    testBroadcast();
    testCentral();
    testIdReadOnly();
    testTurnaround();
    testAbortWrite();
    testAbortRead();
    testUnmapped();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule